// File: doc/BRIEF.md
# Dual-Pointer XY Address Generator

This block produces the word addresses for a parallel transfer that reads or writes an X data memory and a Y data memory in the same cycle. Each side owns a small pointer set: two address pointers, one index register and a pair of modulo bounds (start and end). Every cycle each side may be asked for an access. The request names which of its two pointers to use and how that pointer moves afterwards: it can stay put, step by one word (2 bytes), or step by the side's index register. The memory is always addressed with the pointer value from before the update, and the updated value is written back into the pointer.

The two sides have separate adders and separate registers, so both complete their update in the same cycle without sharing anything. When modulo is enabled for a side, a pointer that has reached that side's end address reloads the start address instead of stepping, which forms a circular buffer. A single write port loads pointers, index registers and modulo bounds by register number.

Top module: `xy_agu`

## Requirements
- R1: After a synchronous active-low reset, every pointer, index and bound register reads zero, both valid outputs are low, and both address and write-back outputs are zero.
- R2: A side whose enable is low in a cycle shows its valid output low in the next cycle, keeps its address and write-back outputs unchanged, and does not change its pointers.
- R3: An enabled request drives, one cycle later, the valid output high and the address output equal to the selected pointer's value before the update. Select 0/1 picks register 4/5 on the X side and 6/7 on the Y side.
- R4: Mode code 00 (hold) leaves the selected pointer unchanged; code 11 behaves the same as 00.
- R5: Mode code 01 adds 2 to the selected pointer (modulo 2^AW).
- R6: Mode code 10 adds the side's index register (register 8 for X, register 9 for Y) to the selected pointer, modulo 2^AW.
- R7: With the side's modulo enable high and mode 01 or 10, a selected pointer equal to the side's end register is reloaded with the side's start register (X start/end are registers 10/11, Y start/end are 12/13) instead of stepping.
- R8: The write-back output, valid together with the address, shows the new pointer value computed for the request.
- R9: The write port stores wr_data into the register numbered wr_num (4 to 13) at the clock edge, readable from the next cycle; when it targets a pointer being updated in the same cycle, the written value is kept. Other numbers change nothing.
- R10: The X and Y sides operate independently and both complete a request in the same cycle.
- R11: Bit 0 of each address output is always zero, even when the pointer holds an odd value; the pointer itself keeps its bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| x_en | input | 1 | X-side access request |
| x_sel | input | 1 | X pointer select (0: reg 4, 1: reg 5) |
| x_mode | input | 2 | X update mode (00 hold, 01 +2, 10 +index, 11 hold) |
| x_mod_en | input | 1 | X modulo wrap enable |
| y_en | input | 1 | Y-side access request |
| y_sel | input | 1 | Y pointer select (0: reg 6, 1: reg 7) |
| y_mode | input | 2 | Y update mode, same codes as X |
| y_mod_en | input | 1 | Y modulo wrap enable |
| wr_en | input | 1 | Register write strobe |
| wr_num | input | 4 | Register number to write (4..13) |
| wr_data | input | AW | Value to write |
| x_addr | output | AW | X memory word address |
| x_addr_vld | output | 1 | X address valid |
| x_wb | output | AW | Updated X pointer value |
| y_addr | output | AW | Y memory word address |
| y_addr_vld | output | 1 | Y address valid |
| y_wb | output | AW | Updated Y pointer value |

## Verification
Every output of a side is registered once, so the address, valid and write-back for a request sampled at one rising edge are due right after that edge, and the moved pointer is what the following request sees. A register write is likewise visible to a request one cycle later. The bench drives inputs on the falling edge, computes the expected outputs from its own register model at that moment, and compares them at the next falling edge, which sits half a period after the edge where the result appears.

// File: rtl/xy_agu_pkg.sv
package xy_agu_pkg;

    // Post-update behaviour selected per side and per request.
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'b00,
        UPD_INC2  = 2'b01,
        UPD_INDEX = 2'b10,
        UPD_RSVD  = 2'b11
    } upd_mode_e;

    localparam int REG_NUM_W  = 4;
    localparam int WORD_BYTES = 2;

    // Register numbers seen by the write port.
    localparam logic [REG_NUM_W-1:0] RN_XP0  = 4'd4;
    localparam logic [REG_NUM_W-1:0] RN_XP1  = 4'd5;
    localparam logic [REG_NUM_W-1:0] RN_YP0  = 4'd6;
    localparam logic [REG_NUM_W-1:0] RN_YP1  = 4'd7;
    localparam logic [REG_NUM_W-1:0] RN_XIDX = 4'd8;
    localparam logic [REG_NUM_W-1:0] RN_YIDX = 4'd9;
    localparam logic [REG_NUM_W-1:0] RN_XBEG = 4'd10;
    localparam logic [REG_NUM_W-1:0] RN_XEND = 4'd11;
    localparam logic [REG_NUM_W-1:0] RN_YBEG = 4'd12;
    localparam logic [REG_NUM_W-1:0] RN_YEND = 4'd13;

endpackage

// File: rtl/xy_agu_next.sv
module xy_agu_next
    import xy_agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] beg,
    input  logic [AW-1:0] fin,
    input  upd_mode_e     mode,
    input  logic          mod_en,
    output logic [AW-1:0] nxt
);

    localparam logic [AW-1:0] STEP_WORD = AW'(WORD_BYTES);

    logic [AW-1:0] step;
    logic [AW-1:0] sum;
    logic          moving;
    logic          wrap;

    always_comb begin
        unique case (mode)
            UPD_INC2:  step = STEP_WORD;
            UPD_INDEX: step = idx;
            default:   step = '0;
        endcase
        moving = (mode == UPD_INC2) || (mode == UPD_INDEX);
        sum    = cur + step;
        wrap   = moving && mod_en && (cur == fin);
        if (wrap) begin
            nxt = beg;
        end else if (moving) begin
            nxt = sum;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/xy_agu_lane.sv
module xy_agu_lane
    import xy_agu_pkg::*;
#(
    parameter int                     AW     = 16,
    parameter logic [REG_NUM_W-1:0]   RN_P0  = 4'd4,
    parameter logic [REG_NUM_W-1:0]   RN_P1  = 4'd5,
    parameter logic [REG_NUM_W-1:0]   RN_IDX = 4'd8,
    parameter logic [REG_NUM_W-1:0]   RN_BEG = 4'd10,
    parameter logic [REG_NUM_W-1:0]   RN_END = 4'd11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_en,
    input  logic                 req_sel,
    input  upd_mode_e            req_mode,
    input  logic                 mod_en,
    input  logic                 wr_en,
    input  logic [REG_NUM_W-1:0] wr_num,
    input  logic [AW-1:0]        wr_data,
    output logic [AW-1:0]        acc_addr,
    output logic                 acc_vld,
    output logic [AW-1:0]        wb_ptr
);

    typedef struct packed {
        logic [1:0][AW-1:0] ptr;
        logic [AW-1:0]      idx;
        logic [AW-1:0]      beg;
        logic [AW-1:0]      fin;
        logic [AW-1:0]      addr;
        logic [AW-1:0]      wb;
        logic               vld;
    } lane_st_t;

    lane_st_t      st_d;
    lane_st_t      st_q;
    logic [AW-1:0] cur;
    logic [AW-1:0] nxt;

    assign cur = st_q.ptr[req_sel];

    xy_agu_next #(.AW(AW)) u_next (
        .cur    (cur),
        .idx    (st_q.idx),
        .beg    (st_q.beg),
        .fin    (st_q.fin),
        .mode   (req_mode),
        .mod_en (mod_en),
        .nxt    (nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (req_en) begin
            st_d.addr          = {cur[AW-1:1], 1'b0};
            st_d.vld           = 1'b1;
            st_d.wb            = nxt;
            st_d.ptr[req_sel]  = nxt;
        end
        // A register write lands after the update so it wins a collision.
        if (wr_en) begin
            if (wr_num == RN_P0)  st_d.ptr[0] = wr_data;
            if (wr_num == RN_P1)  st_d.ptr[1] = wr_data;
            if (wr_num == RN_IDX) st_d.idx    = wr_data;
            if (wr_num == RN_BEG) st_d.beg    = wr_data;
            if (wr_num == RN_END) st_d.fin    = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_addr = st_q.addr;
    assign acc_vld  = st_q.vld;
    assign wb_ptr   = st_q.wb;

endmodule

// File: rtl/xy_agu.sv
module xy_agu
    import xy_agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 x_en,
    input  logic                 x_sel,
    input  logic [1:0]           x_mode,
    input  logic                 x_mod_en,
    input  logic                 y_en,
    input  logic                 y_sel,
    input  logic [1:0]           y_mode,
    input  logic                 y_mod_en,
    input  logic                 wr_en,
    input  logic [REG_NUM_W-1:0] wr_num,
    input  logic [AW-1:0]        wr_data,
    output logic [AW-1:0]        x_addr,
    output logic                 x_addr_vld,
    output logic [AW-1:0]        x_wb,
    output logic [AW-1:0]        y_addr,
    output logic                 y_addr_vld,
    output logic [AW-1:0]        y_wb
);

    localparam int NSIDE = 2;

    localparam logic [REG_NUM_W-1:0] P0_TAB  [NSIDE] = '{RN_XP0,  RN_YP0};
    localparam logic [REG_NUM_W-1:0] P1_TAB  [NSIDE] = '{RN_XP1,  RN_YP1};
    localparam logic [REG_NUM_W-1:0] IDX_TAB [NSIDE] = '{RN_XIDX, RN_YIDX};
    localparam logic [REG_NUM_W-1:0] BEG_TAB [NSIDE] = '{RN_XBEG, RN_YBEG};
    localparam logic [REG_NUM_W-1:0] END_TAB [NSIDE] = '{RN_XEND, RN_YEND};

    logic [NSIDE-1:0]         en_v;
    logic [NSIDE-1:0]         sel_v;
    logic [NSIDE-1:0][1:0]    mode_v;
    logic [NSIDE-1:0]         mod_v;
    logic [NSIDE-1:0][AW-1:0] addr_v;
    logic [NSIDE-1:0]         vld_v;
    logic [NSIDE-1:0][AW-1:0] wb_v;

    assign en_v   = {y_en, x_en};
    assign sel_v  = {y_sel, x_sel};
    assign mode_v = {y_mode, x_mode};
    assign mod_v  = {y_mod_en, x_mod_en};

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        xy_agu_lane #(
            .AW     (AW),
            .RN_P0  (P0_TAB[g]),
            .RN_P1  (P1_TAB[g]),
            .RN_IDX (IDX_TAB[g]),
            .RN_BEG (BEG_TAB[g]),
            .RN_END (END_TAB[g])
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_en   (en_v[g]),
            .req_sel  (sel_v[g]),
            .req_mode (upd_mode_e'(mode_v[g])),
            .mod_en   (mod_v[g]),
            .wr_en    (wr_en),
            .wr_num   (wr_num),
            .wr_data  (wr_data),
            .acc_addr (addr_v[g]),
            .acc_vld  (vld_v[g]),
            .wb_ptr   (wb_v[g])
        );
    end

    assign x_addr     = addr_v[0];
    assign x_addr_vld = vld_v[0];
    assign x_wb       = wb_v[0];
    assign y_addr     = addr_v[1];
    assign y_addr_vld = vld_v[1];
    assign y_wb       = wb_v[1];

endmodule

// File: rtl/xy_agu_chk.sv
module xy_agu_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          x_en,
    input logic [1:0]    x_mode,
    input logic          x_mod_en,
    input logic          y_en,
    input logic [1:0]    y_mode,
    input logic          y_mod_en,
    input logic [AW-1:0] x_addr,
    input logic          x_addr_vld,
    input logic [AW-1:0] x_wb,
    input logic [AW-1:0] y_addr,
    input logic          y_addr_vld,
    input logic [AW-1:0] y_wb
);

    localparam logic [AW-2:0] ONE_WORD = {{(AW-2){1'b0}}, 1'b1};

    // R3
    x_req_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_en |=> x_addr_vld);
    // R3
    y_req_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_en |=> y_addr_vld);
    // R2
    x_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !x_en |=> !x_addr_vld);
    // R2
    y_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !y_en |=> !y_addr_vld);
    // R2
    x_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !x_addr_vld |-> $stable(x_addr) && $stable(x_wb));
    // R2
    y_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !y_addr_vld |-> $stable(y_addr) && $stable(y_wb));
    // R11
    x_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_addr_vld |-> !x_addr[0]);
    // R11
    y_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_addr_vld |-> !y_addr[0]);
    // R4
    x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_addr_vld && ($past(x_mode) == 2'b00 || $past(x_mode) == 2'b11)
        |-> x_wb[AW-1:1] == x_addr[AW-1:1]);
    // R4
    y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_addr_vld && ($past(y_mode) == 2'b00 || $past(y_mode) == 2'b11)
        |-> y_wb[AW-1:1] == y_addr[AW-1:1]);
    // R5
    x_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_addr_vld && $past(x_mode) == 2'b01 && !$past(x_mod_en)
        |-> x_wb[AW-1:1] == x_addr[AW-1:1] + ONE_WORD);
    // R5
    y_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_addr_vld && $past(y_mode) == 2'b01 && !$past(y_mod_en)
        |-> y_wb[AW-1:1] == y_addr[AW-1:1] + ONE_WORD);

endmodule

bind xy_agu xy_agu_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .x_en       (x_en),
    .x_mode     (x_mode),
    .x_mod_en   (x_mod_en),
    .y_en       (y_en),
    .y_mode     (y_mode),
    .y_mod_en   (y_mod_en),
    .x_addr     (x_addr),
    .x_addr_vld (x_addr_vld),
    .x_wb       (x_wb),
    .y_addr     (y_addr),
    .y_addr_vld (y_addr_vld),
    .y_wb       (y_wb)
);

// File: tb/tb_xy_agu.sv
`timescale 1ns/1ps
module tb_xy_agu;

    localparam int AW       = 16;
    localparam int HALF_NS  = 4;
    localparam int WD_LIMIT = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          x_en = 1'b0, x_sel = 1'b0, x_mod_en = 1'b0;
    logic [1:0]    x_mode = 2'b00;
    logic          y_en = 1'b0, y_sel = 1'b0, y_mod_en = 1'b0;
    logic [1:0]    y_mode = 2'b00;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_num = 4'd0;
    logic [AW-1:0] wr_data = '0;
    logic [AW-1:0] x_addr, x_wb, y_addr, y_wb;
    logic          x_addr_vld, y_addr_vld;

    int n_chk = 0;
    int n_err = 0;

    // Behavioural model: register file indexed by register number.
    logic [AW-1:0] mr [16];
    logic          ev [2];
    logic [AW-1:0] ea [2];
    logic [AW-1:0] ew [2];
    string         en_note [2];
    bit            pend = 1'b0;

    always #(HALF_NS) clk = ~clk;

    xy_agu #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .x_en(x_en), .x_sel(x_sel), .x_mode(x_mode), .x_mod_en(x_mod_en),
        .y_en(y_en), .y_sel(y_sel), .y_mode(y_mode), .y_mod_en(y_mod_en),
        .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
        .x_addr(x_addr), .x_addr_vld(x_addr_vld), .x_wb(x_wb),
        .y_addr(y_addr), .y_addr_vld(y_addr_vld), .y_wb(y_wb)
    );

    task automatic chk(input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic compare();
        chk({"R2 R3 x valid ", en_note[0]}, {{(AW-1){1'b0}}, x_addr_vld}, {{(AW-1){1'b0}}, ev[0]});
        chk({"R2 R3 y valid ", en_note[1]}, {{(AW-1){1'b0}}, y_addr_vld}, {{(AW-1){1'b0}}, ev[1]});
        chk({"R3 x addr ", en_note[0]}, x_addr, ea[0]);
        chk({"R8 x wb ", en_note[0]}, x_wb, ew[0]);
        chk({"R3 y addr ", en_note[1]}, y_addr, ea[1]);
        chk({"R8 y wb ", en_note[1]}, y_wb, ew[1]);
    endtask

    task automatic side_model(input int s, input bit en, input bit sel,
                              input logic [1:0] mode, input bit md, input string note);
        if (!en) begin
            ev[s] = 1'b0;
            en_note[s] = {note, " R2 idle"};
        end else begin
            int            pn  = 4 + 2*s + int'(sel);
            logic [AW-1:0] old = mr[pn];
            logic [AW-1:0] nx  = old;
            string         n;
            bit            mv  = (mode == 2'b01) || (mode == 2'b10);
            if (mode == 2'b01) nx = old + AW'(2);
            if (mode == 2'b10) nx = old + mr[8 + s];
            if (mv && md && old == mr[11 + 2*s]) begin
                nx = mr[10 + 2*s];
                n  = "R7 wrap";
            end else if (mode == 2'b01) n = "R5 inc";
            else if (mode == 2'b10) n = "R6 index";
            else n = "R4 hold";
            if (old[0]) n = {n, " R11 odd"};
            if (s == 1) n = {n, " R10"};
            ev[s] = 1'b1;
            ea[s] = {old[AW-1:1], 1'b0};
            ew[s] = nx;
            mr[pn] = nx;
            en_note[s] = {note, " ", n};
        end
    endtask

    task automatic cyc(input bit xe, input bit xs, input logic [1:0] xm, input bit xmo,
                       input bit ye, input bit ys, input logic [1:0] ym, input bit ymo,
                       input bit we, input logic [3:0] wn, input logic [AW-1:0] wd,
                       input string note);
        @(negedge clk);
        if (pend) compare();
        x_en = xe; x_sel = xs; x_mode = xm; x_mod_en = xmo;
        y_en = ye; y_sel = ys; y_mode = ym; y_mod_en = ymo;
        wr_en = we; wr_num = wn; wr_data = wd;
        side_model(0, xe, xs, xm, xmo, note);
        side_model(1, ye, ys, ym, ymo, note);
        if (we && wn >= 4'd4 && wn <= 4'd13) mr[wn] = wd;
        pend = 1'b1;
    endtask

    task automatic wreg(input logic [3:0] wn, input logic [AW-1:0] wd, input string note);
        cyc(0, 0, 2'b00, 0, 0, 0, 2'b00, 0, 1, wn, wd, note);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mr[i] = '0;
        for (int i = 0; i < 2; i++) begin
            ev[i] = 1'b0; ea[i] = '0; ew[i] = '0; en_note[i] = "R1 reset";
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        chk("R1 x valid in reset", {{(AW-1){1'b0}}, x_addr_vld}, '0);
        chk("R1 y valid in reset", {{(AW-1){1'b0}}, y_addr_vld}, '0);
        chk("R1 x addr in reset", x_addr, '0);
        chk("R1 y wb in reset", y_wb, '0);
        rst_n = 1'b1;

        // R1: every pointer reads zero after reset
        cyc(1, 0, 2'b00, 0, 1, 0, 2'b00, 0, 0, 0, '0, "R1");
        cyc(1, 1, 2'b11, 0, 1, 1, 2'b11, 0, 0, 0, '0, "R1");

        // R9: load registers through the write port
        wreg(4'd4,  16'h0010, "R9 load");
        wreg(4'd5,  16'h0021, "R9 load");
        wreg(4'd6,  16'h0100, "R9 load");
        wreg(4'd7,  16'h0200, "R9 load");
        wreg(4'd8,  16'h0006, "R9 load");
        wreg(4'd9,  16'hFFFC, "R9 load");
        wreg(4'd15, 16'hBEEF, "R9 unused number");

        // R10: both sides move in one cycle
        cyc(1, 0, 2'b01, 0, 1, 1, 2'b10, 0, 0, 0, '0, "R10 both");
        // R11: odd pointer, address bit 0 cleared
        cyc(1, 1, 2'b10, 0, 1, 0, 2'b00, 0, 0, 0, '0, "R11 odd");
        // R9: write collides with an update of the same pointer
        cyc(1, 0, 2'b01, 0, 0, 0, 2'b00, 0, 1, 4'd4, 16'h0444, "R9 collide");
        cyc(1, 0, 2'b00, 0, 0, 0, 2'b00, 0, 0, 0, '0, "R9 after collide");
        // R5: top-of-range increment wraps modulo 2^AW
        wreg(4'd6, 16'hFFFE, "R5 edge");
        cyc(0, 0, 2'b00, 0, 1, 0, 2'b01, 0, 0, 0, '0, "R5 overflow");
        cyc(0, 0, 2'b00, 0, 1, 0, 2'b00, 0, 0, 0, '0, "R5 overflow read");

        // Random traffic without modulo
        for (int k = 0; k < 800; k++) begin
            bit we = ($urandom_range(0, 9) == 0);
            cyc($urandom_range(0, 3) != 0, 1'($urandom), 2'($urandom), 0,
                $urandom_range(0, 3) != 0, 1'($urandom), 2'($urandom), 0,
                we, 4'($urandom), AW'($urandom), "rand");
        end

        // R7: circular buffers on both sides
        wreg(4'd10, 16'h0100, "R7 setup");
        wreg(4'd11, 16'h010C, "R7 setup");
        wreg(4'd12, 16'h0300, "R7 setup");
        wreg(4'd13, 16'h0318, "R7 setup");
        wreg(4'd4,  16'h0100, "R7 setup");
        wreg(4'd5,  16'h0104, "R7 setup");
        wreg(4'd6,  16'h0300, "R7 setup");
        wreg(4'd7,  16'h0308, "R7 setup");
        wreg(4'd8,  16'h0004, "R7 setup");
        wreg(4'd9,  16'h0008, "R7 setup");
        for (int k = 0; k < 10; k++)
            cyc(1, 0, 2'b01, 1, 1, 1, 2'b10, 1, 0, 0, '0, "R7 directed");
        for (int k = 0; k < 1200; k++) begin
            cyc($urandom_range(0, 3) != 0, 1'($urandom), 2'($urandom), 1,
                $urandom_range(0, 3) != 0, 1'($urandom), 2'($urandom), 1,
                0, 0, '0, "R7 rand");
        end
        cyc(0, 0, 2'b00, 0, 0, 0, 2'b00, 0, 0, 0, '0, "R2 tail");
        @(negedge clk);
        compare();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule